// File: doc/BRIEF.md
# Bus Access Test Counter

This peripheral lets a host check that its bus writes actually reach a device. It has two byte-wide request ports: a memory window spanning 4096 bytes and an I/O window spanning 256 bytes. A write to offset 0 of either window picks one of six test slots. The slot number is three times the window type (memory 0, I/O 1) plus the written test mode (0 plain, 1 wildcard, 2 data-match). The selected slot then counts the qualifying writes that land on its trigger offset.

The active slot can be read back through either window as a small little-endian header. The header holds the slot number, the access width, the trigger offset, the expected data byte, the running write count and a NUL-terminated name string. A test program selects a slot and fires writes at the trigger offset. It then reads the count to see how many of those writes arrived and passed the slot's filter. Requests on the two ports are served one per clock, and a read returns its byte one cycle after it is accepted.

Top module: `bus_test_counter`

## Requirements
- R1: A write to address 0 on either window first deactivates the current slot. If the written byte is below 3, slot (window type × 3 + byte) becomes active, with window type 0 for memory and 1 for I/O, and its count is cleared to 0. If the byte is 3 or more, no slot is active afterwards.
- R2: Header bytes of the active slot: byte 0 holds the slot number, byte 1 holds the access width 1, and bytes 2, 3, 9, 10 and 11 read 0.
- R3: Header bytes 4 to 7 hold the trigger offset as a little-endian 32-bit value. The offset is 2048 + slot for memory slots (0..2) and 128 + slot for I/O slots (3..5). A write is counted only when a slot is active and the write address equals this offset.
- R4: A wildcard slot (mode 1) has expected byte 0xCE in header byte 8. It counts every write to its trigger offset, whatever the data and the size.
- R5: Plain (mode 0) and data-match (mode 2) slots have expected byte 0xFA in header byte 8. They count a write to the trigger offset only when its size is 1 and its data is 0xFA.
- R6: Header bytes 12 to 15 hold the write count as a little-endian 32-bit value. Each counted write adds one.
- R7: A read returns 0 when no slot is active, or when address + size is greater than or equal to the header length (16 + name length + 1).
- R8: The name starts at header byte 16 and reads "<type>-<mode>". The type is "mmio" or "portio". The mode is "no-eventfd", "wildcard-eventfd" or "datamatch-eventfd".
- R9: Reads never change the count. Both windows read the same header of the active slot.
- R10: Reset leaves no slot active, so all reads return 0.
- R11: The memory port is always ready. The I/O port is not ready in any cycle where the memory port is valid. An accepted read raises the rvalid of its own window for one cycle, in the cycle after acceptance, with the byte on that window's rdata. An accepted write raises no rvalid.
- R12: Trigger matching ignores the window that carried the write. A memory-window write to an I/O slot's trigger offset counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_valid | input | 1 | Memory window request valid |
| mem_ready | output | 1 | Memory window request accepted |
| mem_we | input | 1 | Memory request is a write |
| mem_addr | input | 12 | Memory window byte address |
| mem_wdata | input | 8 | Memory write data byte |
| mem_size | input | 4 | Memory access size in bytes |
| mem_rvalid | output | 1 | Memory read data valid |
| mem_rdata | output | 8 | Memory read data byte |
| io_valid | input | 1 | I/O window request valid |
| io_ready | output | 1 | I/O window request accepted |
| io_we | input | 1 | I/O request is a write |
| io_addr | input | 8 | I/O window byte address |
| io_wdata | input | 8 | I/O write data byte |
| io_size | input | 4 | I/O access size in bytes |
| io_rvalid | output | 1 | I/O read data valid |
| io_rdata | output | 8 | I/O read data byte |

## Verification
The assertions assume that request inputs are known after reset. They also assume that an I/O request refused while the memory port is valid is held by the requester, not counted as served; the response and count properties only look at requests that were accepted. The stimulus changes inputs only on the falling clock edge. It keeps each request up for exactly one rising edge, except in the contention case, where the I/O request is held until it is accepted. It also uses only addresses inside each window's span.

// File: rtl/bat_pkg.sv
// Package for the bus access test counter: shared constants, the internal
// request type and the name string generator for the six test slots.
package bat_pkg;

    localparam int REQ_AW        = 16;
    localparam int SIZE_W        = 4;
    localparam int NUM_MODES     = 3;
    localparam int NUM_WINS      = 2;
    localparam int NUM_SLOTS     = NUM_MODES * NUM_WINS;
    localparam int SLOT_W        = $clog2(NUM_SLOTS);
    localparam int CNT_W         = 32;
    localparam int HDR_NAME_BASE = 16;
    localparam int ACC_WIDTH     = 1;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_WILD  = 2'd1,
        MODE_MATCH = 2'd2
    } mode_e;

    typedef enum logic {
        WIN_MEM = 1'b0,
        WIN_IO  = 1'b1
    } win_e;

    typedef struct packed {
        logic                  we;
        win_e                  win;
        logic [REQ_AW-1:0]     addr;
        logic [7:0]            data;
        logic [SIZE_W-1:0]     size;
    } acc_t;

    localparam logic [8*5-1:0]  TXT_MEM   = "mmio-";
    localparam logic [8*7-1:0]  TXT_IO    = "portio-";
    localparam logic [8*10-1:0] TXT_PLAIN = "no-eventfd";
    localparam logic [8*16-1:0] TXT_WILD  = "wildcard-eventfd";
    localparam logic [8*17-1:0] TXT_MATCH = "datamatch-eventfd";

    // Length of the window-type part of a name, dash included.
    function automatic int prefix_len(input win_e w);
        return (w == WIN_IO) ? 7 : 5;
    endfunction

    // Length of the mode part of a name.
    function automatic int suffix_len(input mode_e m);
        case (m)
            MODE_PLAIN: return 10;
            MODE_WILD:  return 16;
            default:    return 17;
        endcase
    endfunction

    // Total name length, terminator excluded.
    function automatic int name_len(input win_e w, input mode_e m);
        return prefix_len(w) + suffix_len(m);
    endfunction

    // Character k of a slot name; 0 past the end (terminator and beyond).
    function automatic logic [7:0] name_char(input win_e w, input mode_e m, input int k);
        int pl;
        int j;
        logic [7:0] c;
        pl = prefix_len(w);
        c  = 8'h00;
        if (k >= 0 && k < pl) begin
            if (w == WIN_IO) c = TXT_IO[8*(6-k) +: 8];
            else             c = TXT_MEM[8*(4-k) +: 8];
        end else if (k >= pl) begin
            j = k - pl;
            if (j < suffix_len(m)) begin
                case (m)
                    MODE_PLAIN: c = TXT_PLAIN[8*(9-j) +: 8];
                    MODE_WILD:  c = TXT_WILD[8*(15-j) +: 8];
                    default:    c = TXT_MATCH[8*(16-j) +: 8];
                endcase
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/tc_req_arb.sv
// Request arbiter: merges the memory and I/O request ports into one access
// per cycle. The memory port has fixed priority; the I/O port is held off
// while the memory port is valid. Assumes both address widths fit REQ_AW.
module tc_req_arb
    import bat_pkg::*;
#(
    parameter int MEM_AW = 12,
    parameter int IO_AW  = 8
) (
    input  logic              mem_valid,
    input  logic              mem_we,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic [SIZE_W-1:0] mem_size,
    output logic              mem_ready,
    input  logic              io_valid,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [SIZE_W-1:0] io_size,
    output logic              io_ready,
    output logic              acc_valid,
    output acc_t              acc
);

    // Grant: memory first, I/O only when memory is idle.
    always_comb begin
        mem_ready = 1'b1;
        io_ready  = ~mem_valid;
        acc_valid = mem_valid | io_valid;
        acc       = '0;
        if (mem_valid) begin
            acc.we   = mem_we;
            acc.win  = WIN_MEM;
            acc.addr = REQ_AW'(mem_addr);
            acc.data = mem_wdata;
            acc.size = mem_size;
        end else if (io_valid) begin
            acc.we   = io_we;
            acc.win  = WIN_IO;
            acc.addr = REQ_AW'(io_addr);
            acc.data = io_wdata;
            acc.size = io_size;
        end
    end

endmodule

// File: rtl/tc_slot_ctrl.sv
// Slot controller: holds which test slot is active and its write count.
// A write to address 0 reselects the slot; qualifying trigger writes count.
// One counter serves all slots, since a slot's count is cleared whenever it
// becomes active and only the active slot is visible.
module tc_slot_ctrl
    import bat_pkg::*;
#(
    parameter int         MEM_WIN    = 2048,
    parameter int         IO_WIN     = 128,
    parameter logic [7:0] MATCH_BYTE = 8'hFA,
    parameter logic [7:0] WILD_BYTE  = 8'hCE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  acc_t              acc,
    output logic              slot_active,
    output win_e              slot_win,
    output mode_e             slot_mode,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [REQ_AW-1:0] trig_addr,
    output logic [7:0]        exp_byte,
    output logic [CNT_W-1:0]  slot_count
);

    logic is_select;
    logic data_ok;
    logic hit;

    // Slot number, trigger offset and expected byte of the held selection.
    always_comb begin
        slot_idx  = ((slot_win == WIN_IO) ? SLOT_W'(NUM_MODES) : SLOT_W'(0)) + SLOT_W'(slot_mode);
        trig_addr = REQ_AW'((slot_win == WIN_IO) ? IO_WIN : MEM_WIN) + REQ_AW'(slot_idx);
        exp_byte  = (slot_mode == MODE_WILD) ? WILD_BYTE : MATCH_BYTE;
    end

    // Classify the current access: selection write or counted trigger write.
    always_comb begin
        is_select = acc_valid && acc.we && (acc.addr == '0);
        data_ok   = (slot_mode == MODE_WILD) ||
                    ((acc.size == SIZE_W'(1)) && (acc.data == MATCH_BYTE));
        hit       = acc_valid && acc.we && slot_active && (acc.addr == trig_addr) && data_ok;
    end

    // Selection state and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_active <= 1'b0;
            slot_win    <= WIN_MEM;
            slot_mode   <= MODE_PLAIN;
            slot_count  <= '0;
        end else if (is_select) begin
            slot_active <= (acc.data < 8'(NUM_MODES));
            if (acc.data < 8'(NUM_MODES)) begin
                slot_win   <= acc.win;
                slot_mode  <= mode_e'(acc.data[1:0]);
                slot_count <= '0;
            end
        end else if (hit) begin
            slot_count <= slot_count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tc_hdr_view.sv
// Header view: produces the byte of the active slot's header at a read
// address. The header is never stored; each byte is derived from the slot
// state. Out-of-range or idle reads give 0.
module tc_hdr_view
    import bat_pkg::*;
(
    input  logic              slot_active,
    input  win_e              slot_win,
    input  mode_e             slot_mode,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [REQ_AW-1:0] trig_addr,
    input  logic [7:0]        exp_byte,
    input  logic [CNT_W-1:0]  slot_count,
    input  logic [REQ_AW-1:0] rd_addr,
    input  logic [SIZE_W-1:0] rd_size,
    output logic [7:0]        rd_byte
);

    logic [31:0] trig_word;
    int          hdr_len;
    int          span;

    // Header length and the end of the requested access.
    always_comb begin
        trig_word = 32'(trig_addr);
        hdr_len   = HDR_NAME_BASE + name_len(slot_win, slot_mode) + 1;
        span      = int'(rd_addr) + int'(rd_size);
    end

    // Byte select over the header layout.
    always_comb begin
        rd_byte = 8'h00;
        if (slot_active && (span < hdr_len)) begin
            case (rd_addr)
                16'd0:   rd_byte = 8'(slot_idx);
                16'd1:   rd_byte = 8'(ACC_WIDTH);
                16'd4:   rd_byte = trig_word[7:0];
                16'd5:   rd_byte = trig_word[15:8];
                16'd6:   rd_byte = trig_word[23:16];
                16'd7:   rd_byte = trig_word[31:24];
                16'd8:   rd_byte = exp_byte;
                16'd12:  rd_byte = slot_count[7:0];
                16'd13:  rd_byte = slot_count[15:8];
                16'd14:  rd_byte = slot_count[23:16];
                16'd15:  rd_byte = slot_count[31:24];
                default: begin
                    if (rd_addr >= REQ_AW'(HDR_NAME_BASE))
                        rd_byte = name_char(slot_win, slot_mode, int'(rd_addr) - HDR_NAME_BASE);
                end
            endcase
        end
    end

endmodule

// File: rtl/bus_test_counter.sv
// Bus access test counter top: two byte-wide request windows (memory and
// I/O), one access served per clock, read data registered one cycle after
// acceptance on the window that asked. Assumes requesters hold a refused
// request until it is accepted.
module bus_test_counter
    import bat_pkg::*;
#(
    parameter int         MEM_WIN    = 2048,
    parameter int         IO_WIN     = 128,
    parameter logic [7:0] MATCH_BYTE = 8'hFA,
    parameter logic [7:0] WILD_BYTE  = 8'hCE,
    localparam int        MEM_AW     = $clog2(2 * MEM_WIN),
    localparam int        IO_AW      = $clog2(2 * IO_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic              mem_we,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic [SIZE_W-1:0] mem_size,
    output logic              mem_rvalid,
    output logic [7:0]        mem_rdata,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [SIZE_W-1:0] io_size,
    output logic              io_rvalid,
    output logic [7:0]        io_rdata
);

    logic              acc_valid;
    acc_t              acc;
    logic              slot_active;
    win_e              slot_win;
    mode_e             slot_mode;
    logic [SLOT_W-1:0] slot_idx;
    logic [REQ_AW-1:0] trig_addr;
    logic [7:0]        exp_byte;
    logic [CNT_W-1:0]  slot_count;
    logic [7:0]        view_byte;
    logic              rd_take;

    tc_req_arb #(
        .MEM_AW (MEM_AW),
        .IO_AW  (IO_AW)
    ) i_arb (
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_size  (mem_size),
        .mem_ready (mem_ready),
        .io_valid  (io_valid),
        .io_we     (io_we),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_size   (io_size),
        .io_ready  (io_ready),
        .acc_valid (acc_valid),
        .acc       (acc)
    );

    tc_slot_ctrl #(
        .MEM_WIN    (MEM_WIN),
        .IO_WIN     (IO_WIN),
        .MATCH_BYTE (MATCH_BYTE),
        .WILD_BYTE  (WILD_BYTE)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc         (acc),
        .slot_active (slot_active),
        .slot_win    (slot_win),
        .slot_mode   (slot_mode),
        .slot_idx    (slot_idx),
        .trig_addr   (trig_addr),
        .exp_byte    (exp_byte),
        .slot_count  (slot_count)
    );

    tc_hdr_view i_view (
        .slot_active (slot_active),
        .slot_win    (slot_win),
        .slot_mode   (slot_mode),
        .slot_idx    (slot_idx),
        .trig_addr   (trig_addr),
        .exp_byte    (exp_byte),
        .slot_count  (slot_count),
        .rd_addr     (acc.addr),
        .rd_size     (acc.size),
        .rd_byte     (view_byte)
    );

    // An accepted read this cycle.
    assign rd_take = acc_valid && !acc.we;

    // Read response registers, one set per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            io_rvalid  <= 1'b0;
            mem_rdata  <= 8'h00;
            io_rdata   <= 8'h00;
        end else begin
            mem_rvalid <= rd_take && (acc.win == WIN_MEM);
            io_rvalid  <= rd_take && (acc.win == WIN_IO);
            if (rd_take && (acc.win == WIN_MEM)) mem_rdata <= view_byte;
            if (rd_take && (acc.win == WIN_IO))  io_rdata  <= view_byte;
        end
    end

endmodule

// File: rtl/tc_check.sv
// Checker for the bus access test counter: port-level timing of the two
// windows, counter stepping and idle-read behaviour. Bound into the top.
module tc_check #(
    parameter int MEM_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_rvalid,
    input logic [7:0]        mem_rdata,
    input logic              io_valid,
    input logic              io_ready,
    input logic              io_we,
    input logic              io_rvalid,
    input logic              slot_active,
    input logic [31:0]       slot_count
);

    p_io_yields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && io_valid) |-> !io_ready);

    p_mem_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_we) |=> (mem_rvalid && !io_rvalid));

    p_io_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready && !io_we) |=> (io_rvalid && !mem_rvalid));

    p_write_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> (!mem_rvalid && !io_rvalid));

    p_one_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rvalid && io_rvalid));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_count) |-> ((slot_count == $past(slot_count) + 32'd1) || (slot_count == 32'd0)));

    p_read_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_valid && mem_we) && !(io_valid && io_ready && io_we)) |=> $stable(slot_count));

    p_idle_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_active && mem_valid && mem_ready && !mem_we) |=> (mem_rdata == 8'h00));

    p_bad_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && (mem_addr == '0) && (mem_wdata >= 8'd3)) |=> !slot_active);

endmodule

bind bus_test_counter tc_check #(.MEM_AW(MEM_AW)) i_tc_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .io_valid    (io_valid),
    .io_ready    (io_ready),
    .io_we       (io_we),
    .io_rvalid   (io_rvalid),
    .slot_active (slot_active),
    .slot_count  (slot_count)
);

// File: tb/test_bus_test_counter.sv
`timescale 1ns/1ps
module test_bus_test_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_valid = 1'b0, mem_we = 1'b0;
    logic [11:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [3:0]  mem_size = 4'd1;
    logic        io_valid = 1'b0, io_we = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [3:0]  io_size = 4'd1;
    logic        mem_ready, io_ready, mem_rvalid, io_rvalid;
    logic [7:0]  mem_rdata, io_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_test_counter i_bus_test_counter (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .io_valid(io_valid), .io_ready(io_ready), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_size(io_size),
        .io_rvalid(io_rvalid), .io_rdata(io_rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One request on one window, held for a single rising edge.
    task automatic access(input bit io, input bit we, input int addr, input logic [7:0] d,
                          input int sz, output logic [7:0] rd);
        @(negedge clk);
        if (io) begin
            io_valid = 1'b1; io_we = we; io_addr = 8'(addr); io_wdata = d; io_size = 4'(sz);
        end else begin
            mem_valid = 1'b1; mem_we = we; mem_addr = 12'(addr); mem_wdata = d; mem_size = 4'(sz);
        end
        @(posedge clk);
        #1;
        rd = io ? io_rdata : mem_rdata;
        chk("R11", we ? "rvalid after write" : "rvalid after read",
            32'(io ? io_rvalid : mem_rvalid), we ? 32'd0 : 32'd1);
        mem_valid = 1'b0;
        io_valid  = 1'b0;
    endtask

    task automatic wr(input bit io, input int addr, input logic [7:0] d, input int sz);
        logic [7:0] junk;
        access(io, 1'b1, addr, d, sz, junk);
    endtask

    task automatic rd(input bit io, input int addr, input int sz, output logic [7:0] v);
        access(io, 1'b0, addr, 8'h00, sz, v);
    endtask

    task automatic rd32(input bit io, input int addr, output logic [31:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 4; i++) begin
            rd(io, addr + i, 1, b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] b;
        rd(1'b0, 0, 1, b);  chk("R10", "mem byte 0 after reset", 32'(b), 32'd0);
        rd(1'b1, 8, 1, b);  chk("R10", "io byte 8 after reset", 32'(b), 32'd0);
        rd(1'b0, 16, 1, b); chk("R7", "idle name read", 32'(b), 32'd0);
    endtask

    task automatic t_layout();
        logic [7:0]  b;
        logic [31:0] w;
        wr(1'b0, 0, 8'd0, 1);
        rd(1'b0, 0, 1, b); chk("R2", "slot 0 index", 32'(b), 32'd0);
        rd(1'b0, 1, 1, b); chk("R2", "width byte", 32'(b), 32'd1);
        rd(1'b0, 2, 1, b); chk("R2", "pad byte 2", 32'(b), 32'd0);
        rd(1'b0, 3, 1, b); chk("R2", "pad byte 3", 32'(b), 32'd0);
        rd(1'b0, 10, 1, b); chk("R2", "pad byte 10", 32'(b), 32'd0);
        rd32(1'b0, 4, w);  chk("R3", "slot 0 trigger", w, 32'd2048);
        rd(1'b0, 8, 1, b); chk("R5", "slot 0 expected byte", 32'(b), 32'hFA);
        rd32(1'b0, 12, w); chk("R1", "count cleared", w, 32'd0);
        wr(1'b1, 0, 8'd0, 1);
        rd(1'b1, 0, 1, b); chk("R1", "io select 0 gives slot 3", 32'(b), 32'd3);
        rd32(1'b1, 4, w);  chk("R3", "slot 3 trigger", w, 32'd131);
        wr(1'b0, 0, 8'd2, 1);
        rd(1'b0, 0, 1, b); chk("R1", "mem select 2 gives slot 2", 32'(b), 32'd2);
        rd32(1'b0, 4, w);  chk("R3", "slot 2 trigger", w, 32'd2050);
    endtask

    task automatic t_names();
        string nm [6] = '{"mmio-no-eventfd", "mmio-wildcard-eventfd", "mmio-datamatch-eventfd",
                          "portio-no-eventfd", "portio-wildcard-eventfd", "portio-datamatch-eventfd"};
        logic [7:0] b;
        for (int s = 0; s < 6; s++) begin
            int len;
            len = nm[s].len();
            wr(s >= 3, 0, 8'(s % 3), 1);
            for (int k = 0; k < len; k++) begin
                rd(1'b0, 16 + k, 1, b);
                chk("R8", $sformatf("slot %0d name char %0d", s, k), 32'(b), 32'(nm[s][k]));
            end
            rd(1'b1, 16 + len - 1, 2, b);
            chk("R7", $sformatf("slot %0d read ending at header length", s), 32'(b), 32'd0);
            rd(1'b0, 16 + len, 1, b);
            chk("R8", $sformatf("slot %0d terminator", s), 32'(b), 32'd0);
        end
    endtask

    task automatic t_match_filter();
        logic [31:0] w;
        logic [7:0]  b;
        wr(1'b0, 0, 8'd2, 1);
        wr(1'b0, 2050, 8'hFA, 1);
        wr(1'b0, 2050, 8'h11, 1);
        wr(1'b0, 2050, 8'hFA, 2);
        wr(1'b0, 2049, 8'hFA, 1);
        rd32(1'b0, 12, w); chk("R5", "data-match count", w, 32'd1);
        wr(1'b0, 2050, 8'hFA, 1);
        rd32(1'b0, 12, w); chk("R5", "data-match second hit", w, 32'd2);
        wr(1'b0, 0, 8'd0, 1);
        wr(1'b0, 2048, 8'hFA, 1);
        wr(1'b0, 2048, 8'hCE, 1);
        wr(1'b0, 2050, 8'hFA, 1);
        rd32(1'b0, 12, w); chk("R5", "plain mode count", w, 32'd1);
        rd(1'b0, 8, 1, b); chk("R5", "plain expected byte", 32'(b), 32'hFA);
    endtask

    task automatic t_wildcard();
        logic [31:0] w;
        logic [7:0]  b;
        wr(1'b1, 0, 8'd1, 1);
        rd(1'b1, 0, 1, b); chk("R1", "slot 4 selected", 32'(b), 32'd4);
        rd(1'b1, 8, 1, b); chk("R4", "wildcard expected byte", 32'(b), 32'hCE);
        wr(1'b1, 132, 8'h00, 4);
        wr(1'b1, 132, 8'hCE, 1);
        wr(1'b1, 132, 8'hFA, 2);
        wr(1'b1, 133, 8'hCE, 1);
        rd32(1'b1, 12, w); chk("R4", "wildcard count", w, 32'd3);
        wr(1'b1, 0, 8'd1, 1);
        rd32(1'b1, 12, w); chk("R1", "reselect clears count", w, 32'd0);
    endtask

    task automatic t_bad_select();
        logic [7:0] b;
        wr(1'b0, 0, 8'd0, 1);
        wr(1'b1, 0, 8'd3, 1);
        rd(1'b0, 0, 1, b); chk("R1", "select 3 leaves none active", 32'(b), 32'd0);
        rd(1'b0, 1, 1, b); chk("R7", "idle width read", 32'(b), 32'd0);
        wr(1'b0, 0, 8'd1, 1);
        wr(1'b0, 0, 8'hFF, 1);
        rd(1'b1, 1, 1, b); chk("R1", "select 0xFF leaves none active", 32'(b), 32'd0);
    endtask

    task automatic t_count_order();
        logic [31:0] w;
        logic [7:0]  b;
        wr(1'b1, 0, 8'd1, 1);
        for (int i = 0; i < 300; i++) wr(1'b1, 132, 8'(i), 1);
        rd32(1'b1, 12, w); chk("R6", "count of 300", w, 32'd300);
        rd(1'b1, 13, 1, b); chk("R6", "count high byte", 32'(b), 32'h01);
        rd(1'b1, 12, 1, b); chk("R6", "count low byte", 32'(b), 32'h2C);
        for (int i = 0; i < 10; i++) rd(1'b0, 12, 1, b);
        rd32(1'b0, 12, w); chk("R9", "reads leave count, mem window view", w, 32'd300);
    endtask

    task automatic t_cross_window();
        logic [31:0] w;
        wr(1'b1, 0, 8'd0, 1);
        wr(1'b0, 131, 8'hFA, 1);
        wr(1'b0, 131, 8'h00, 1);
        rd32(1'b1, 12, w); chk("R12", "memory write hits I/O slot", w, 32'd1);
        chk("R3", "only trigger write with right data counted", w, 32'd1);
    endtask

    task automatic t_contention();
        wr(1'b0, 0, 8'd0, 1);
        @(negedge clk);
        mem_valid = 1'b1; mem_we = 1'b0; mem_addr = 12'd8; mem_size = 4'd1;
        io_valid  = 1'b1; io_we  = 1'b0; io_addr  = 8'd1;  io_size  = 4'd1;
        #1;
        chk("R11", "io not ready under contention", 32'(io_ready), 32'd0);
        chk("R11", "mem ready under contention", 32'(mem_ready), 32'd1);
        @(posedge clk); #1;
        chk("R11", "mem rvalid first", 32'(mem_rvalid), 32'd1);
        chk("R11", "io rvalid held off", 32'(io_rvalid), 32'd0);
        chk("R11", "mem read data", 32'(mem_rdata), 32'hFA);
        mem_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11", "io rvalid second", 32'(io_rvalid), 32'd1);
        chk("R9", "io reads same header", 32'(io_rdata), 32'd1);
        io_valid = 1'b0;
    endtask

    task automatic t_reset_mid();
        logic [7:0] b;
        wr(1'b0, 0, 8'd2, 1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, 0, 1, b);  chk("R10", "slot gone after reset", 32'(b), 32'd0);
        rd(1'b1, 8, 1, b);  chk("R10", "expected byte gone after reset", 32'(b), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_layout();
        t_names();
        t_match_filter();
        t_wildcard();
        t_bad_select();
        t_count_order();
        t_cross_window();
        t_contention();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule